// File: doc/BRIEF.md
# Cascadable Product-Term Sum Array

This block is a configurable sum-of-products fabric made of sixteen identical slices. A selection stage routes forty signals from a wide global bus onto local lines. Each slice then evaluates five AND terms over those forty lines plus a sixteen-line regional bus. Every literal of every term is set by a two-bit code: ignore, true, complement, or both polarities. A slice ORs the terms it enables. It can then take in the sum of its neighbour below, so neighbouring slices build wide sums. A final XOR stage inverts the sum or combines it with one of the slice's own terms.

Every slice also returns one inverted term to the regional bus, where all sixteen slices can read it. Through De Morgan's law, this lets one term of a slice stand for the OR of many terms spread over other slices. All configuration is applied as static mask and select inputs, and the whole array is combinational.

Top module: `pterm_sum_array`

## Requirements
- R1: Selected line j (0..39) carries `glob_bus[idx_j]` while `cfg_sel_en[j]` is 1, where `idx_j = cfg_sel_idx[6j+5:6j]`, and carries 0 while `cfg_sel_en[j]` is 0.
- R2: Term t of slice s reads its literal code for input n from `cfg_lit` bits starting at ((s*5+t)*56+n)*2. Inputs 0..39 are the selected lines and input 40+k is `fold_out[k]`. Code 00 ignores the input, 01 requires it high, 10 requires it low, and 11 forces the term to 0.
- R3: A term whose 56 codes are all 00 evaluates to 1. A term whose bit `cfg_or_en[s*5+t]` is 0 adds nothing to the sum.
- R4: The local sum of a slice is the OR of its enabled terms, so up to five terms are summed in one slice.
- R5: `casc_out[s]` is the local sum ORed with `casc_out[s-1]` when `cfg_casc_en[s]` is 1. Slices 0 and 8 never take a cascade, which caps a chain at eight slices and 40 terms.
- R6: `sum_out[s]` is `casc_out[s]` XOR an operand chosen by the mode `cfg_xor_mode[2s+1:2s]`: 00 gives 0, 01 gives 1, 10 gives term number `cfg_xor_pt[3s+2:3s]`, and 11 gives 0.
- R7: A term claimed as the XOR operand (mode 10) or as the foldback source (`cfg_fb_en[s]`=1, index `cfg_fb_pt[3s+2:3s]`) is left out of the OR sum even when its OR enable is set.
- R8: `fold_out[s]` is 1 when `cfg_fb_en[s]` is 0. Otherwise it is the inverse of the chosen term's AND over inputs 0..39 only, because the term's regional literals are not part of the foldback.
- R9: Foldback lines used as true literals in one term, with mode 01, make a slice output the OR of terms evaluated in other slices.
- R10: A term index of 5, 6 or 7 selects no term. Mode 10 then yields operand 0, the foldback stays 1, and no term is removed from the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| glob_bus | input | 64 | Global signal bus |
| cfg_sel_idx | input | 240 | Six-bit source index per selected line |
| cfg_sel_en | input | 40 | Enable per selected line |
| cfg_lit | input | 8960 | Two-bit literal code per slice, term and input |
| cfg_or_en | input | 80 | OR enable per term |
| cfg_xor_mode | input | 32 | XOR operand mode per slice |
| cfg_xor_pt | input | 48 | XOR operand term index per slice |
| cfg_fb_en | input | 16 | Foldback enable per slice |
| cfg_fb_pt | input | 48 | Foldback source term index per slice |
| cfg_casc_en | input | 16 | Take cascade from slice below |
| sum_out | output | 16 | XOR stage output per slice |
| casc_out | output | 16 | Sum passed along the chain per slice |
| fold_out | output | 16 | Regional foldback line per slice |

## Verification
The case that needs care is a term that is enabled into the OR and, at the same settle, claimed by the XOR stage or by the foldback. The bench provokes this by setting the OR enable on the claimed term and then driving a pattern in which only that term is true. The expected result is a cascade output of 0 together with an inverted XOR result or a low foldback line. Mode 11 and out-of-range indices are then applied to show the claim is released and the term counts in the sum again.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

    // Two-bit literal code for one input of one product term
    typedef enum logic [1:0] {
        LIT_IGNORE = 2'b00,
        LIT_TRUE   = 2'b01,
        LIT_COMP   = 2'b10,
        LIT_BOTH   = 2'b11
    } lit_e;

    // Second operand of the polarity stage
    typedef enum logic [1:0] {
        XOR_ZERO = 2'b00,
        XOR_ONE  = 2'b01,
        XOR_TERM = 2'b10,
        XOR_RSVD = 2'b11
    } xor_mode_e;

    // Per-slice results
    typedef struct packed {
        logic sum;
        logic casc;
        logic fold;
    } slice_out_t;

    function automatic logic lit_pass(input logic [1:0] code, input logic v);
        logic r;
        case (lit_e'(code))
            LIT_TRUE: r = v;
            LIT_COMP: r = ~v;
            LIT_BOTH: r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pterm_input_sel.sv
module pterm_input_sel #(
    parameter int GLOBAL_W = 64,
    parameter int SEL_N    = 40,
    parameter int IDX_W    = $clog2(GLOBAL_W)
) (
    input  logic [GLOBAL_W-1:0]    glob_bus,
    input  logic [SEL_N*IDX_W-1:0] cfg_sel_idx,
    input  logic [SEL_N-1:0]       cfg_sel_en,
    output logic [SEL_N-1:0]       sel_line
);

    localparam bit IDX_OVERRANGE = ((1 << IDX_W) > GLOBAL_W);

    logic [SEL_N-1:0] in_range;

    generate
        if (IDX_OVERRANGE) begin : g_chk
            always_comb begin
                for (int j = 0; j < SEL_N; j++) begin
                    in_range[j] = (int'(cfg_sel_idx[j*IDX_W +: IDX_W]) < GLOBAL_W);
                end
            end
        end else begin : g_nochk
            assign in_range = '1;
        end
    endgenerate

    always_comb begin
        for (int j = 0; j < SEL_N; j++) begin
            sel_line[j] = cfg_sel_en[j] & in_range[j] &
                          glob_bus[cfg_sel_idx[j*IDX_W +: IDX_W]];
        end
    end

    // R1: a switched-off line stays low whatever the bus carries
    always_comb begin
        for (int j = 0; j < SEL_N; j++) begin
            if (!cfg_sel_en[j]) begin
                a_r1_off_line_low: assert (!sel_line[j])
                    else $error("R1 disabled line %0d is high", j);
            end
        end
    end

endmodule

// File: rtl/pterm_term.sv
module pterm_term
    import pterm_pkg::*;
#(
    parameter int SEL_N = 40,
    parameter int N_FB  = 16,
    parameter int TIN   = SEL_N + N_FB
) (
    input  logic [SEL_N-1:0] sel_line,
    input  logic [N_FB-1:0]  fb_line,
    input  logic [TIN*2-1:0] lits,
    output logic             glob_and,
    output logic             term
);

    logic reg_and;

    // Global part: selected lines only (feeds the foldback, so it must not
    // depend on the regional bus)
    always_comb begin
        glob_and = 1'b1;
        for (int n = 0; n < SEL_N; n++) begin
            glob_and = glob_and & lit_pass(lits[n*2 +: 2], sel_line[n]);
        end
    end

    // Regional part: foldback lines
    always_comb begin
        reg_and = 1'b1;
        for (int k = 0; k < N_FB; k++) begin
            reg_and = reg_and & lit_pass(lits[(SEL_N+k)*2 +: 2], fb_line[k]);
        end
    end

    assign term = glob_and & reg_and;

    // R2: a true term needs its global part true
    always_comb begin
        if (term) begin
            a_r2_term_has_global: assert (glob_and)
                else $error("R2 term high while global part low");
        end
    end

    // R3: an all-ignore term is 1
    always_comb begin
        if (lits == '0) begin
            a_r3_empty_term_one: assert (term)
                else $error("R3 empty term evaluated low");
        end
    end

endmodule

// File: rtl/pterm_slice.sv
module pterm_slice
    import pterm_pkg::*;
#(
    parameter int SEL_N    = 40,
    parameter int N_FB     = 16,
    parameter int N_PT     = 5,
    parameter int PT_IDX_W = $clog2(N_PT),
    parameter int TIN      = SEL_N + N_FB
) (
    input  logic [SEL_N-1:0]       sel_line,
    input  logic [N_FB-1:0]        fb_line,
    input  logic [N_PT*TIN*2-1:0]  lits,
    input  logic [N_PT-1:0]        or_en,
    input  logic [1:0]             xor_mode,
    input  logic [PT_IDX_W-1:0]    xor_pt,
    input  logic                   fb_en,
    input  logic [PT_IDX_W-1:0]    fb_pt,
    input  logic                   casc_in,
    output slice_out_t             res
);

    logic [N_PT-1:0] glob;
    logic [N_PT-1:0] term;
    logic [N_PT-1:0] xor_claim;
    logic [N_PT-1:0] fb_claim;
    logic [N_PT-1:0] eff_en;
    logic            local_or;
    logic            operand;

    generate
        for (genvar t = 0; t < N_PT; t++) begin : g_term
            pterm_term #(
                .SEL_N (SEL_N),
                .N_FB  (N_FB),
                .TIN   (TIN)
            ) term_i (
                .sel_line (sel_line),
                .fb_line  (fb_line),
                .lits     (lits[t*TIN*2 +: TIN*2]),
                .glob_and (glob[t]),
                .term     (term[t])
            );
        end
    endgenerate

    // Which terms are taken by control functions
    always_comb begin
        for (int t = 0; t < N_PT; t++) begin
            xor_claim[t] = (xor_mode_e'(xor_mode) == XOR_TERM) &&
                           (xor_pt == PT_IDX_W'(t));
            fb_claim[t]  = fb_en && (fb_pt == PT_IDX_W'(t));
        end
        eff_en = or_en & ~xor_claim & ~fb_claim;
    end

    assign local_or = |(term & eff_en);

    always_comb begin
        if (xor_mode_e'(xor_mode) == XOR_ONE) operand = 1'b1;
        else                                  operand = |(term & xor_claim);
    end

    assign res.casc = local_or | casc_in;
    assign res.sum  = res.casc ^ operand;
    assign res.fold = ~|(glob & fb_claim);

    // R5: an arriving cascade always reaches the output of the chain stage
    always_comb begin
        if (casc_in) begin
            a_r5_casc_passes: assert (res.casc)
                else $error("R5 cascade lost in slice");
        end
    end

    // R6: constant-zero operand leaves the sum untouched
    always_comb begin
        if (xor_mode_e'(xor_mode) == XOR_ZERO) begin
            a_r6_zero_keeps_sum: assert (res.sum == res.casc)
                else $error("R6 sum changed under zero operand");
        end
    end

    // R7: a claimed term never drives the OR
    always_comb begin
        for (int t = 0; t < N_PT; t++) begin
            if (xor_claim[t] || fb_claim[t]) begin
                a_r7_claimed_term_out: assert (!eff_en[t])
                    else $error("R7 claimed term %0d left in sum", t);
            end
        end
    end

    // R8: a low foldback line needs an enabled foldback
    always_comb begin
        if (!res.fold) begin
            a_r8_fold_needs_enable: assert (fb_en)
                else $error("R8 foldback low while disabled");
        end
    end

endmodule

// File: rtl/pterm_sum_array.sv
module pterm_sum_array
    import pterm_pkg::*;
#(
    parameter int GLOBAL_W  = 64,
    parameter int SEL_N     = 40,
    parameter int N_SLICE   = 16,
    parameter int N_PT      = 5,
    parameter int CHAIN_LEN = 8
) (
    input  logic [GLOBAL_W-1:0]                          glob_bus,
    input  logic [SEL_N*$clog2(GLOBAL_W)-1:0]            cfg_sel_idx,
    input  logic [SEL_N-1:0]                             cfg_sel_en,
    input  logic [N_SLICE*N_PT*(SEL_N+N_SLICE)*2-1:0]    cfg_lit,
    input  logic [N_SLICE*N_PT-1:0]                      cfg_or_en,
    input  logic [N_SLICE*2-1:0]                         cfg_xor_mode,
    input  logic [N_SLICE*$clog2(N_PT)-1:0]              cfg_xor_pt,
    input  logic [N_SLICE-1:0]                           cfg_fb_en,
    input  logic [N_SLICE*$clog2(N_PT)-1:0]              cfg_fb_pt,
    input  logic [N_SLICE-1:0]                           cfg_casc_en,
    output logic [N_SLICE-1:0]                           sum_out,
    output logic [N_SLICE-1:0]                           casc_out,
    output logic [N_SLICE-1:0]                           fold_out
);

    localparam int IDX_W    = $clog2(GLOBAL_W);
    localparam int PT_IDX_W = $clog2(N_PT);
    localparam int TIN      = SEL_N + N_SLICE;
    localparam int SLICE_LW = N_PT * TIN * 2;

    logic [SEL_N-1:0]   sel_line;
    logic [N_SLICE-1:0] fold_bus;

    pterm_input_sel #(
        .GLOBAL_W (GLOBAL_W),
        .SEL_N    (SEL_N),
        .IDX_W    (IDX_W)
    ) sel_i (
        .glob_bus    (glob_bus),
        .cfg_sel_idx (cfg_sel_idx),
        .cfg_sel_en  (cfg_sel_en),
        .sel_line    (sel_line)
    );

    generate
        for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
            logic       prev;
            logic       c_in;
            slice_out_t so;

            if ((s % CHAIN_LEN) == 0) begin : g_head
                assign prev = 1'b0;
            end else begin : g_link
                assign prev = g_slice[s-1].so.casc;
            end

            assign c_in = cfg_casc_en[s] & prev;

            pterm_slice #(
                .SEL_N    (SEL_N),
                .N_FB     (N_SLICE),
                .N_PT     (N_PT),
                .PT_IDX_W (PT_IDX_W),
                .TIN      (TIN)
            ) slice_i (
                .sel_line (sel_line),
                .fb_line  (fold_bus),
                .lits     (cfg_lit[s*SLICE_LW +: SLICE_LW]),
                .or_en    (cfg_or_en[s*N_PT +: N_PT]),
                .xor_mode (cfg_xor_mode[s*2 +: 2]),
                .xor_pt   (cfg_xor_pt[s*PT_IDX_W +: PT_IDX_W]),
                .fb_en    (cfg_fb_en[s]),
                .fb_pt    (cfg_fb_pt[s*PT_IDX_W +: PT_IDX_W]),
                .casc_in  (c_in),
                .res      (so)
            );

            assign fold_bus[s] = so.fold;
            assign sum_out[s]  = so.sum;
            assign casc_out[s] = so.casc;
            assign fold_out[s] = so.fold;

            // R5: a linked slice carries the sum of the slice below
            if ((s % CHAIN_LEN) != 0) begin : g_chain_chk
                always_comb begin
                    if (cfg_casc_en[s] && g_slice[s-1].so.casc) begin
                        a_r5_chain_link: assert (so.casc)
                            else $error("R5 chain broken at slice %0d", s);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: tb/pterm_sum_array_tb_top.sv
module pterm_sum_array_tb_top;

    localparam int GW = 64;
    localparam int SN = 40;
    localparam int NS = 16;
    localparam int NP = 5;
    localparam int TI = SN + NS;

    localparam logic [1:0] L_IGN = 2'b00;
    localparam logic [1:0] L_T   = 2'b01;
    localparam logic [1:0] L_C   = 2'b10;
    localparam logic [1:0] L_B   = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [GW-1:0]         glob_bus;
    logic [SN*6-1:0]       cfg_sel_idx;
    logic [SN-1:0]         cfg_sel_en;
    logic [NS*NP*TI*2-1:0] cfg_lit;
    logic [NS*NP-1:0]      cfg_or_en;
    logic [NS*2-1:0]       cfg_xor_mode;
    logic [NS*3-1:0]       cfg_xor_pt;
    logic [NS-1:0]         cfg_fb_en;
    logic [NS*3-1:0]       cfg_fb_pt;
    logic [NS-1:0]         cfg_casc_en;
    logic [NS-1:0]         sum_out;
    logic [NS-1:0]         casc_out;
    logic [NS-1:0]         fold_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    pterm_sum_array dut_i (
        .glob_bus     (glob_bus),
        .cfg_sel_idx  (cfg_sel_idx),
        .cfg_sel_en   (cfg_sel_en),
        .cfg_lit      (cfg_lit),
        .cfg_or_en    (cfg_or_en),
        .cfg_xor_mode (cfg_xor_mode),
        .cfg_xor_pt   (cfg_xor_pt),
        .cfg_fb_en    (cfg_fb_en),
        .cfg_fb_pt    (cfg_fb_pt),
        .cfg_casc_en  (cfg_casc_en),
        .sum_out      (sum_out),
        .casc_out     (casc_out),
        .fold_out     (fold_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg_clear();
        glob_bus     = '0;
        cfg_sel_idx  = '0;
        cfg_sel_en   = '0;
        cfg_lit      = '0;
        cfg_or_en    = '0;
        cfg_xor_mode = '0;
        cfg_xor_pt   = '0;
        cfg_fb_en    = '0;
        cfg_fb_pt    = '0;
        cfg_casc_en  = '0;
    endtask

    task automatic sel(input int j, input int idx);
        cfg_sel_idx[j*6 +: 6] = 6'(idx);
        cfg_sel_en[j] = 1'b1;
    endtask

    task automatic set_lit(input int s, input int t, input int n, input logic [1:0] c);
        cfg_lit[((s*NP+t)*TI+n)*2 +: 2] = c;
    endtask

    task automatic set_or(input int s, input int t);
        cfg_or_en[s*NP+t] = 1'b1;
    endtask

    task automatic set_xor(input int s, input int mode, input int pt);
        cfg_xor_mode[s*2 +: 2] = 2'(mode);
        cfg_xor_pt[s*3 +: 3]   = 3'(pt);
    endtask

    task automatic set_fb(input int s, input int pt);
        cfg_fb_en[s] = 1'b1;
        cfg_fb_pt[s*3 +: 3] = 3'(pt);
    endtask

    task automatic t_idle();
        cfg_clear();
        settle();
        check("R3 idle sum", sum_out, 16'h0000);
        check("R4 idle casc", casc_out, 16'h0000);
        check("R8 idle fold", fold_out, 16'hFFFF);
    endtask

    task automatic t_select();
        cfg_clear();
        sel(0, 13);
        set_lit(0, 0, 0, L_T);
        set_or(0, 0);
        glob_bus = 64'd1 << 13; settle();
        check("R1 routed high", 16'(sum_out[0]), 16'h1);
        glob_bus = '0; settle();
        check("R1 routed low", 16'(sum_out[0]), 16'h0);
        cfg_sel_en[0] = 1'b0; glob_bus = 64'd1 << 13; settle();
        check("R1 disabled line", 16'(sum_out[0]), 16'h0);
        cfg_sel_en[0] = 1'b1; set_lit(0, 0, 0, L_C);
        glob_bus = '0; settle();
        check("R2 complement low", 16'(sum_out[0]), 16'h1);
        glob_bus = 64'd1 << 13; settle();
        check("R2 complement high", 16'(sum_out[0]), 16'h0);
        set_lit(0, 0, 0, L_B);
        settle();
        check("R2 both high", 16'(sum_out[0]), 16'h0);
        glob_bus = '0; settle();
        check("R2 both low", 16'(sum_out[0]), 16'h0);
        sel(0, 63); set_lit(0, 0, 0, L_T);
        glob_bus = 64'd1 << 63; settle();
        check("R1 top index", 16'(sum_out[0]), 16'h1);
    endtask

    task automatic t_empty();
        cfg_clear();
        set_or(1, 2);
        glob_bus = 64'hA5A5_0000_FFFF_1234; settle();
        check("R3 empty term", sum_out, 16'h0002);
        cfg_or_en[1*NP+2] = 1'b0; settle();
        check("R3 disabled term", sum_out, 16'h0000);
    endtask

    task automatic t_or();
        cfg_clear();
        for (int k = 0; k < NP; k++) begin
            sel(k, k);
            set_lit(2, k, k, L_T);
            set_or(2, k);
        end
        glob_bus = '0; settle();
        check("R4 no term", 16'(casc_out[2]), 16'h0);
        for (int k = 0; k < NP; k++) begin
            glob_bus = 64'd1 << k; settle();
            check("R4 single term", 16'(casc_out[2]), 16'h1);
        end
        cfg_or_en[2*NP+3] = 1'b0;
        glob_bus = 64'd1 << 3; settle();
        check("R3 term off", 16'(casc_out[2]), 16'h0);
    endtask

    task automatic t_casc();
        cfg_clear();
        for (int s = 0; s < 8; s++) begin
            sel(s, s);
            set_lit(s, 0, s, L_T);
            set_or(s, 0);
            if (s > 0) cfg_casc_en[s] = 1'b1;
        end
        cfg_casc_en[8] = 1'b1;
        glob_bus = 64'd1; settle();
        check("R5 full chain", casc_out, 16'h00FF);
        check("R6 zero mode", sum_out, 16'h00FF);
        glob_bus = 64'd1 << 5; settle();
        check("R5 mid entry", casc_out, 16'h00E0);
        cfg_casc_en[3] = 1'b0;
        glob_bus = 64'd1; settle();
        check("R5 broken link", casc_out, 16'h0007);
        glob_bus = 64'd1 << 3; settle();
        check("R5 restart", casc_out, 16'h00F8);
    endtask

    task automatic t_xor();
        cfg_clear();
        sel(0, 0); sel(1, 1);
        set_lit(4, 0, 0, L_T); set_lit(4, 1, 1, L_T);
        set_or(4, 0); set_or(4, 1);
        set_xor(4, 1, 0);
        glob_bus = 64'd1; settle();
        check("R6 one mode casc", 16'(casc_out[4]), 16'h1);
        check("R6 one mode sum", 16'(sum_out[4]), 16'h0);
        glob_bus = '0; settle();
        check("R6 one mode idle", 16'(sum_out[4]), 16'h1);
        set_xor(4, 2, 1);
        glob_bus = 64'd3; settle();
        check("R6 term mode both", 16'(sum_out[4]), 16'h0);
        glob_bus = 64'd2; settle();
        check("R7 xor term dropped", 16'(casc_out[4]), 16'h0);
        check("R6 term operand", 16'(sum_out[4]), 16'h1);
        glob_bus = 64'd1; settle();
        check("R6 sum only", 16'(sum_out[4]), 16'h1);
        set_xor(4, 3, 1);
        glob_bus = 64'd2; settle();
        check("R6 reserved mode casc", 16'(casc_out[4]), 16'h1);
        check("R6 reserved mode sum", 16'(sum_out[4]), 16'h1);
    endtask

    task automatic t_fold();
        cfg_clear();
        sel(2, 2);
        set_lit(5, 0, 2, L_T);
        set_or(5, 0);
        set_fb(5, 0);
        glob_bus = 64'd1 << 2; settle();
        check("R7 fold term dropped", 16'(casc_out[5]), 16'h0);
        check("R8 fold low", fold_out, 16'hFFDF);
        glob_bus = '0; settle();
        check("R8 fold high", fold_out, 16'hFFFF);
    endtask

    task automatic t_wide();
        cfg_clear();
        sel(3, 3); sel(4, 4);
        set_lit(6, 0, 3, L_T); set_fb(6, 0);
        set_lit(6, 0, SN + 7, L_C);
        set_lit(7, 0, 4, L_T); set_fb(7, 0);
        set_lit(9, 0, SN + 6, L_T);
        set_lit(9, 0, SN + 7, L_T);
        set_or(9, 0);
        set_xor(9, 1, 0);
        glob_bus = '0; settle();
        check("R9 none", 16'(sum_out[9]), 16'h0);
        glob_bus = 64'd1 << 3; settle();
        check("R9 first", 16'(sum_out[9]), 16'h1);
        check("R8 global part only", 16'(fold_out[6]), 16'h0);
        glob_bus = 64'd1 << 4; settle();
        check("R9 second", 16'(sum_out[9]), 16'h1);
        glob_bus = 64'h18; settle();
        check("R9 both", 16'(sum_out[9]), 16'h1);
    endtask

    task automatic t_invalid();
        cfg_clear();
        sel(0, 0);
        set_lit(10, 0, 0, L_T);
        set_or(10, 0);
        set_xor(10, 2, 6);
        set_fb(10, 7);
        glob_bus = 64'd1; settle();
        check("R10 term kept", 16'(casc_out[10]), 16'h1);
        check("R10 operand zero", 16'(sum_out[10]), 16'h1);
        check("R10 fold high", 16'(fold_out[10]), 16'h1);
        glob_bus = '0; settle();
        check("R10 idle", 16'(sum_out[10]), 16'h0);
    endtask

    initial begin
        cfg_clear();
        repeat (2) @(posedge clk);
        t_idle();
        t_select();
        t_empty();
        t_or();
        t_casc();
        t_xor();
        t_fold();
        t_wide();
        t_invalid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule